// File: doc/BRIEF.md
# Peer Doorbell Register Block

This block is the register front end of a device that lets several peers share a memory region and signal one another. The device has a 256-byte window of 32-bit registers. Software uses it to mask and observe its own interrupts, to read its position among the peers, and to ring a doorbell on another peer. A doorbell write carries the target peer and the vector in one data word. The block checks that word against the number of known peers and against the count of valid vectors for each peer. A write that passes the check produces a one-clock notify pulse on the outgoing doorbell port.

Events that arrive for this node's own vectors are handled in one of two ways. In legacy mode an event sets the status register, and a level interrupt line follows the masked status. In message-signalled mode the event instead produces a one-clock pulse on that vector's own output, but only when message interrupts are enabled. Reading the status register returns its value and clears it. The connection logic around the block supplies the peer count, the vector counts per peer and the own position as static inputs.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset, the mask and status registers read zero and `irq_o` and `db_valid_o` are low.
- R2: Address bits [1:0] are ignored when decoding. Word offsets are: mask 0x0, status 0x4, own position 0x8, doorbell 0xC. `rdata_o` presents the read value on the clock after `rd_en_i`.
- R3: A write to the mask or the status register stores all 32 data bits, and a later read returns them.
- R4: A status read returns the current value and clears the register to zero. An own-vector event in legacy mode in the same cycle as the read wins, and the status is left at 1.
- R5: `irq_o` is high exactly when (status AND mask) is nonzero, legacy mode is selected (`msi_mode_i`=0) and `irq_pin_en_i`=1. It follows a register write from the next cycle.
- R6: A doorbell write takes the target peer from data bits [31:16] and the vector from data bits [7:0]. Data bits [15:8] are ignored. An accepted write raises `db_valid_o`, with `db_peer_o` and `db_vec_o`, on the clock after the write, for exactly one cycle.
- R7: A doorbell is dropped when its peer is at or above `known_peers_i` or at or above NUM_PEERS.
- R8: A doorbell is dropped when its vector is at or above that peer's valid-vector count. Peer p's count is at `peer_vec_cnt_i[p*CNT_W +: CNT_W]`.
- R9: In legacy mode, an event on any own vector sets status to 1, whether or not the interrupt pin is enabled.
- R10: In message-signalled mode, `evt_i[k]` pulses `msi_pulse_o[k]` on the next clock for one cycle, but only if `msi_en_i`=1. The status register is not changed.
- R11: A read of the own-position offset returns `own_pos_i` zero-extended. Reads of the doorbell offset or of an undefined offset return zero. Writes to the own-position offset or to an undefined offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| own_pos_i | input | PEER_W | This node's peer position |
| known_peers_i | input | PEER_W | Number of peers currently known |
| peer_vec_cnt_i | input | NUM_PEERS*CNT_W | Valid-vector count for each peer |
| msi_mode_i | input | 1 | 1 selects message-signalled interrupts |
| msi_en_i | input | 1 | Message interrupts enabled |
| irq_pin_en_i | input | 1 | Legacy interrupt pin enabled |
| evt_i | input | NUM_VEC | Incoming events on own vectors |
| irq_o | output | 1 | Legacy level interrupt |
| msi_pulse_o | output | NUM_VEC | Per-vector message interrupt pulses |
| db_valid_o | output | 1 | Outgoing doorbell notify pulse |
| db_peer_o | output | PEER_W | Doorbell target peer |
| db_vec_o | output | VEC_W | Doorbell target vector |

## Verification
The bench uses the default parameters: four peer slots, four vectors, 16-bit peer and 8-bit vector fields. It sets the known-peer input to 3, so the fourth slot has a nonzero count but lies beyond the known range. This covers a rejection caused only by the peer limit, as separate from a peer whose vector count is zero. Peer counts of 4, 0, 2 and 4 place both an accepted and a rejected vector on the same peer. A peer value above 255 checks that the upper peer bits are really compared.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int WADDR_W = ADDR_W - 2;

  localparam logic [WADDR_W-1:0] W_MASK = 6'h0;
  localparam logic [WADDR_W-1:0] W_STAT = 6'h1;
  localparam logic [WADDR_W-1:0] W_POS  = 6'h2;
  localparam logic [WADDR_W-1:0] W_DB   = 6'h3;

  typedef enum logic [2:0] {
    SEL_MASK,
    SEL_STAT,
    SEL_POS,
    SEL_DB,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
(
  input  logic [WADDR_W-1:0] waddr_i,
  output reg_sel_e           sel_o
);
  always_comb begin
    unique case (waddr_i)
      W_MASK:  sel_o = SEL_MASK;
      W_STAT:  sel_o = SEL_STAT;
      W_POS:   sel_o = SEL_POS;
      W_DB:    sel_o = SEL_DB;
      default: sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dbr_irq_ctrl.sv
module dbr_irq_ctrl
  import dbr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_wr_i,
  input  logic              stat_wr_i,
  input  logic              stat_rd_i,
  input  logic              evt_set_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              msi_mode_i,
  input  logic              irq_pin_en_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] mask_q, stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (evt_set_i)      stat_d = DATA_W'(1);
    else if (stat_wr_i) stat_d = wdata_i;
    else if (stat_rd_i) stat_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (mask_wr_i) mask_q <= wdata_i;
      stat_q <= stat_d;
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = (|(stat_q & mask_q)) && !msi_mode_i && irq_pin_en_i;

  // R4
  stat_rd_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !evt_set_i && !stat_wr_i) |=> (stat_o == '0));
  // R5
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_mode_i || !irq_pin_en_i) |-> !irq_o);
  // R9
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_set_i |=> (stat_o == DATA_W'(1)));
endmodule

// File: rtl/dbr_doorbell.sv
module dbr_doorbell #(
  parameter int NUM_PEERS = 4,
  parameter int PEER_W    = 16,
  parameter int VEC_W     = 8,
  parameter int CNT_W     = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       db_wr_i,
  input  logic [PEER_W-1:0]          peer_i,
  input  logic [VEC_W-1:0]           vec_i,
  input  logic [PEER_W-1:0]          known_peers_i,
  input  logic [NUM_PEERS*CNT_W-1:0] peer_vec_cnt_i,
  output logic                       db_valid_o,
  output logic [PEER_W-1:0]          db_peer_o,
  output logic [VEC_W-1:0]           db_vec_o
);
  logic [CNT_W-1:0] cnt_arr [NUM_PEERS];
  logic [CNT_W-1:0] cnt_sel;
  logic             slot_hit;
  logic             accept;

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_cnt
    assign cnt_arr[p] = peer_vec_cnt_i[p*CNT_W +: CNT_W];
  end

  always_comb begin
    cnt_sel  = '0;
    slot_hit = 1'b0;
    for (int p = 0; p < NUM_PEERS; p++) begin
      if (peer_i == PEER_W'(p)) begin
        cnt_sel  = cnt_arr[p];
        slot_hit = 1'b1;
      end
    end
  end

  assign accept = db_wr_i && slot_hit && (peer_i < known_peers_i)
                  && (vec_i < VEC_W'(cnt_sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_valid_o <= 1'b0;
      db_peer_o  <= '0;
      db_vec_o   <= '0;
    end else begin
      db_valid_o <= accept;
      if (accept) begin
        db_peer_o <= peer_i;
        db_vec_o  <= vec_i;
      end
    end
  end

  // R6
  db_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_valid_o |-> $past(db_wr_i));
  // R7
  db_peer_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_valid_o |-> (db_peer_o < $past(known_peers_i)));
endmodule

// File: rtl/dbr_event_route.sv
module dbr_event_route #(
  parameter int NUM_VEC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] evt_i,
  input  logic               msi_mode_i,
  input  logic               msi_en_i,
  output logic               evt_set_o,
  output logic [NUM_VEC-1:0] msi_pulse_o
);
  logic msi_go;

  assign msi_go    = msi_mode_i && msi_en_i;
  assign evt_set_o = !msi_mode_i && (|evt_i);

  for (genvar k = 0; k < NUM_VEC; k++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) msi_pulse_o[k] <= 1'b0;
      else         msi_pulse_o[k] <= evt_i[k] && msi_go;
    end
  end

  // R10
  msi_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|msi_pulse_o) |-> $past(msi_mode_i && msi_en_i));
  // R9
  legacy_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_set_o |-> !msi_mode_i);
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
  import dbr_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int NUM_VEC   = 4,
  parameter int PEER_W    = 16,
  parameter int VEC_W     = 8,
  parameter int CNT_W     = $clog2(NUM_VEC + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  input  logic [PEER_W-1:0]          own_pos_i,
  input  logic [PEER_W-1:0]          known_peers_i,
  input  logic [NUM_PEERS*CNT_W-1:0] peer_vec_cnt_i,
  input  logic                       msi_mode_i,
  input  logic                       msi_en_i,
  input  logic                       irq_pin_en_i,
  input  logic [NUM_VEC-1:0]         evt_i,
  output logic                       irq_o,
  output logic [NUM_VEC-1:0]         msi_pulse_o,
  output logic                       db_valid_o,
  output logic [PEER_W-1:0]          db_peer_o,
  output logic [VEC_W-1:0]           db_vec_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] mask_q, stat_q;
  logic [DATA_W-1:0] rd_val;
  logic              evt_set;

  dbr_decode u_decode (
    .waddr_i (addr_i[ADDR_W-1:2]),
    .sel_o   (sel)
  );

  dbr_event_route #(.NUM_VEC(NUM_VEC)) u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .msi_mode_i  (msi_mode_i),
    .msi_en_i    (msi_en_i),
    .evt_set_o   (evt_set),
    .msi_pulse_o (msi_pulse_o)
  );

  dbr_irq_ctrl u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mask_wr_i    (wr_en_i && sel == SEL_MASK),
    .stat_wr_i    (wr_en_i && sel == SEL_STAT),
    .stat_rd_i    (rd_en_i && sel == SEL_STAT),
    .evt_set_i    (evt_set),
    .wdata_i      (wdata_i),
    .msi_mode_i   (msi_mode_i),
    .irq_pin_en_i (irq_pin_en_i),
    .mask_o       (mask_q),
    .stat_o       (stat_q),
    .irq_o        (irq_o)
  );

  dbr_doorbell #(
    .NUM_PEERS (NUM_PEERS),
    .PEER_W    (PEER_W),
    .VEC_W     (VEC_W),
    .CNT_W     (CNT_W)
  ) u_db (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .db_wr_i        (wr_en_i && sel == SEL_DB),
    .peer_i         (wdata_i[31:16]),
    .vec_i          (wdata_i[VEC_W-1:0]),
    .known_peers_i  (known_peers_i),
    .peer_vec_cnt_i (peer_vec_cnt_i),
    .db_valid_o     (db_valid_o),
    .db_peer_o      (db_peer_o),
    .db_vec_o       (db_vec_o)
  );

  always_comb begin
    unique case (sel)
      SEL_MASK: rd_val = mask_q;
      SEL_STAT: rd_val = stat_q;
      SEL_POS:  rd_val = DATA_W'(own_pos_i);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  // R11
  rd_unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (sel == SEL_DB || sel == SEL_NONE)) |=> (rdata_o == '0));
  // R1
  rst_state_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (mask_q == '0 && stat_q == '0 && !db_valid_o));
endmodule

// File: tb/tb_peer_doorbell_regs.sv
module tb_peer_doorbell_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_PEERS = 4;
  localparam int NUM_VEC = 4;
  localparam int PEER_W = 16;
  localparam int VEC_W = 8;
  localparam int CNT_W = $clog2(NUM_VEC + 1);

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [PEER_W-1:0] own_pos = 16'd2, known = 16'd3;
  logic [NUM_PEERS*CNT_W-1:0] cnts;
  logic msi_mode = 0, msi_en = 0, pin_en = 1;
  logic [NUM_VEC-1:0] evt = 0, msi_pulse;
  logic irq, db_valid;
  logic [PEER_W-1:0] db_peer;
  logic [VEC_W-1:0] db_vec;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // counts: peer0=4 peer1=0 peer2=2 peer3=4
  assign cnts = {3'd4, 3'd2, 3'd0, 3'd4};

  peer_doorbell_regs dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .own_pos_i(own_pos),
    .known_peers_i(known), .peer_vec_cnt_i(cnts), .msi_mode_i(msi_mode),
    .msi_en_i(msi_en), .irq_pin_en_i(pin_en), .evt_i(evt), .irq_o(irq),
    .msi_pulse_o(msi_pulse), .db_valid_o(db_valid), .db_peer_o(db_peer),
    .db_vec_o(db_vec)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 db_valid", 32'(db_valid), 0);
    rd(8'h00, v); chk("R1 mask", v, 0);
    rd(8'h04, v); chk("R1 status", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h00, 32'hDEAD_BEEF); rd(8'h00, v); chk("R3 mask", v, 32'hDEAD_BEEF);
    wr(8'h06, 32'hA5A5_0005); rd(8'h07, v); chk("R2 R3 status unaligned", v, 32'hA5A5_0005);
    rd(8'h04, v); chk("R4 cleared", v, 0);
    rd(8'h08, v); chk("R11 own pos", v, 32'd2);
    rd(8'h0C, v); chk("R11 doorbell read", v, 0);
    rd(8'h10, v); chk("R11 undefined read", v, 0);
    wr(8'h08, 32'h1234_5678); wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h08, v); chk("R11 pos write ignored", v, 32'd2);
    rd(8'h00, v); chk("R11 mask untouched", v, 32'hDEAD_BEEF);
    rd(8'h04, v); chk("R11 status untouched", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h00, 32'h0000_0002); wr(8'h04, 32'h0000_0001);
    chk("R5 disjoint bits", 32'(irq), 0);
    wr(8'h04, 32'h0000_0003);
    chk("R5 asserted", 32'(irq), 1);
    @(negedge clk); msi_mode = 1; #1 chk("R5 msi mode low", 32'(irq), 0);
    msi_mode = 0; pin_en = 0; #1 chk("R5 pin off low", 32'(irq), 0);
    pin_en = 1; #1 chk("R5 back high", 32'(irq), 1);
    rd(8'h04, v); chk("R4 read value", v, 3);
    chk("R4 irq drops", 32'(irq), 0);
    wr(8'h04, 32'h2); wr(8'h00, 0); chk("R5 mask clear", 32'(irq), 0);
    rd(8'h04, v);
  endtask

  task automatic t_doorbell();
    wr(8'h0C, {16'd2, 8'hFF, 8'd1});
    chk("R6 valid", 32'(db_valid), 1);
    chk("R6 peer", 32'(db_peer), 2);
    chk("R6 vec", 32'(db_vec), 1);
    @(negedge clk); chk("R6 one cycle", 32'(db_valid), 0);
    wr(8'h0D, {16'd0, 8'h00, 8'd3});
    chk("R2 R6 unaligned accept", 32'(db_valid), 1);
    chk("R6 vec3", 32'(db_vec), 3);
    wr(8'h0C, {16'd3, 8'h00, 8'd0});
    chk("R7 peer beyond known", 32'(db_valid), 0);
    wr(8'h0C, {16'h0100, 8'h00, 8'd0});
    chk("R7 large peer", 32'(db_valid), 0);
    wr(8'h0C, {16'd1, 8'h00, 8'd0});
    chk("R8 zero count", 32'(db_valid), 0);
    wr(8'h0C, {16'd2, 8'h00, 8'd2});
    chk("R8 vec at count", 32'(db_valid), 0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pin_en = 0;
    @(negedge clk); evt = 4'b0100; @(negedge clk); evt = 0;
    chk("R9 no msi pulse legacy", 32'(msi_pulse), 0);
    rd(8'h04, v); chk("R9 status set", v, 1);
    pin_en = 1;
    wr(8'h00, 1);
    @(negedge clk); evt = 4'b0001; @(negedge clk); evt = 0;
    chk("R9 R5 irq on event", 32'(irq), 1);
    @(negedge clk); rd_en = 1; addr = 8'h04; evt = 4'b1000;
    @(negedge clk); rd_en = 0; evt = 0;
    chk("R4 read returns", rdata, 1);
    rd(8'h04, v); chk("R4 event wins", v, 1);
    rd(8'h04, v); chk("R4 now clear", v, 0);
    msi_mode = 1; msi_en = 1;
    @(negedge clk); evt = 4'b0100; @(negedge clk); evt = 0;
    chk("R10 pulse", 32'(msi_pulse), 32'b0100);
    @(negedge clk); chk("R10 one cycle", 32'(msi_pulse), 0);
    rd(8'h04, v); chk("R10 status unchanged", v, 0);
    msi_en = 0;
    @(negedge clk); evt = 4'b0010; @(negedge clk); evt = 0;
    chk("R10 disabled no pulse", 32'(msi_pulse), 0);
    msi_mode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_regs();
    t_irq();
    t_doorbell();
    t_events();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule